// File: doc/BRIEF.md
# Read-to-Acquire Semaphore Bank

A bank of binary semaphores shared by several bus requesters that need to take turns on common resources: a flash device, a PHY management path, an address-window register and general software critical sections. Each requester owns a simple memory-mapped slave port. Every semaphore has two addresses. A read of the first one is an atomic test-and-set: it takes the semaphore if it is free and returns 1 to that reader only. A read of the second one releases the semaphore. Writes change nothing.

By convention semaphore 2 guards flash, 3 the PHY, 5 the firmware API, 6 is a general software lock and 7 guards the window register. Semaphores 0, 1 and 4 have no fixed role. When a lock read succeeds, the bank records a small tag supplied by the winning requester, usually its port number, so the current holder can be identified. All responses arrive exactly one cycle after the request.

Top module: `sem_bank`

## Requirements
- R1: A synchronous active-high reset frees every semaphore (sem_held = 0), clears every owner field to 0 and drops every rsp_valid.
- R2: Semaphore N has its acquire address at BASE_ADDR + 8*N and its release address at BASE_ADDR + 8*N + 4, with BASE_ADDR = 0x1C000 and N in 0..7. Every request (read or write) gets rsp_valid high for exactly one cycle, in the cycle after the request.
- R3: An acquire read of a free semaphore returns 1 in rsp_rdata (bit 0 set, all other bits 0) and sets that semaphore's bit in sem_held.
- R4: An acquire read of a held semaphore returns 0 and leaves sem_held and the owner field unchanged.
- R5: When several requesters issue acquire reads to the same free semaphore in one cycle, only the lowest-numbered requester gets 1. All the others get 0.
- R6: Acquire reads to different semaphores in the same cycle are each granted independently.
- R7: A release read from any requester frees the semaphore and returns 0. A release read of a semaphore that is already free has no effect.
- R8: Writes to any address change no state, and their response data is 0.
- R9: Reads outside the window [BASE_ADDR, BASE_ADDR + 8*NUM_SEM), or reads whose address has bits [1:0] not equal to 0, return 0 and have no effect.
- R10: On a grant, owner field N (sem_owner bits [4N+3:4N]) takes the winning requester's req_tag. It keeps that value while the semaphore is held and reads 0 while the semaphore is free.
- R11: An acquire read and a release read of the same semaphore in one cycle are resolved against the state at the start of that cycle. If the semaphore was held, the acquire returns 0 and the semaphore ends up free. If it was free, the acquire is granted and the semaphore ends up held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_REQ | Request strobe per requester |
| req_write | input | NUM_REQ | 1 = write, 0 = read, per requester |
| req_addr | input | NUM_REQ*ADDR_W | Byte address per requester |
| req_tag | input | NUM_REQ*OWNER_W | Identity recorded on a grant |
| rsp_valid | output | NUM_REQ | Response strobe, one cycle after request |
| rsp_rdata | output | NUM_REQ*DATA_W | Response data per requester |
| sem_held | output | NUM_SEM | Current state, bit N = semaphore N held |
| sem_owner | output | NUM_SEM*OWNER_W | Tag of each current holder |

## Verification
The bench drives two requesters into the same semaphore in the same cycle. A bank without arbitration would answer 1 to both, which breaks mutual exclusion, and a wrong priority would hand the grant to requester 1. It releases semaphores that are already free, and it sends acquire and release reads to the same semaphore in one cycle. A design that resolved these against the updated state, or let a write act like a read, would leave a semaphore stuck held or free. Out-of-window and misaligned reads are also sent. A decoder that ignores the upper address bits or bits [1:0] would alias them onto a live semaphore and change sem_held.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      ACC_NONE   = 2'd0,
      ACC_LOCK   = 2'd1,
      ACC_UNLOCK = 2'd2
   } sem_acc_e;
endpackage

// File: rtl/sem_addr_dec.sv
module sem_addr_dec
   import sem_pkg::*;
#(
   parameter int              ADDR_W    = 20,
   parameter int              NUM_SEM   = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h1C000,
   localparam int             IDX_W     = $clog2(NUM_SEM)
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   output sem_acc_e          kind,
   output logic [IDX_W-1:0]  idx
);
   localparam int WIN_BYTES = 8 * NUM_SEM;

   logic [ADDR_W-1:0] off;
   logic              in_win;

   always_comb begin
      off    = addr - BASE_ADDR;
      in_win = (addr >= BASE_ADDR) && (off < ADDR_W'(WIN_BYTES)) && (off[1:0] == 2'b00);
      idx    = off[3 +: IDX_W];
      kind   = ACC_NONE;
      if (valid && !write && in_win)
         kind = off[2] ? ACC_UNLOCK : ACC_LOCK;
   end
endmodule

// File: rtl/sem_prio_arb.sv
module sem_prio_arb #(
   parameter int N = 2
) (
   input  logic         enable,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (enable && req[i] && !found) begin
            gnt[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
   parameter int NUM_REQ  = 2,
   parameter int OWNER_W  = 4,
   parameter bit OWNER_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_REQ-1:0]         lock_req,
   input  logic                       release_req,
   input  logic [NUM_REQ*OWNER_W-1:0] tags,
   output logic                       held,
   output logic [NUM_REQ-1:0]         gnt,
   output logic [OWNER_W-1:0]         owner
);
   logic any_gnt;

   sem_prio_arb #(.N(NUM_REQ)) u_arb (
      .enable (~held),
      .req    (lock_req),
      .gnt    (gnt)
   );

   assign any_gnt = |gnt;

   always_ff @(posedge clk) begin
      if (rst)
         held <= 1'b0;
      else if (any_gnt)
         held <= 1'b1;
      else if (release_req)
         held <= 1'b0;
   end

   generate
      if (OWNER_EN) begin : g_owner
         logic [OWNER_W-1:0] win_tag;
         logic [OWNER_W-1:0] owner_q;

         always_comb begin
            win_tag = '0;
            for (int r = 0; r < NUM_REQ; r++)
               if (gnt[r]) win_tag = tags[r*OWNER_W +: OWNER_W];
         end

         always_ff @(posedge clk) begin
            if (rst)
               owner_q <= '0;
            else if (any_gnt)
               owner_q <= win_tag;
            else if (release_req)
               owner_q <= '0;
         end
         assign owner = owner_q;
      end else begin : g_no_owner
         assign owner = '0;
      end
   endgenerate
endmodule

// File: rtl/sem_bank.sv
module sem_bank
   import sem_pkg::*;
#(
   parameter int                NUM_SEM   = 8,
   parameter int                NUM_REQ   = 2,
   parameter int                ADDR_W    = 20,
   parameter int                DATA_W    = 32,
   parameter int                OWNER_W   = 4,
   parameter bit                OWNER_EN  = 1'b1,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h1C000
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_REQ-1:0]         req_valid,
   input  logic [NUM_REQ-1:0]         req_write,
   input  logic [NUM_REQ*ADDR_W-1:0]  req_addr,
   input  logic [NUM_REQ*OWNER_W-1:0] req_tag,
   output logic [NUM_REQ-1:0]         rsp_valid,
   output logic [NUM_REQ*DATA_W-1:0]  rsp_rdata,
   output logic [NUM_SEM-1:0]         sem_held,
   output logic [NUM_SEM*OWNER_W-1:0] sem_owner
);
   localparam int IDX_W = $clog2(NUM_SEM);

   generate
      if (NUM_SEM < 2 || (NUM_SEM & (NUM_SEM - 1)) != 0) begin : g_bad_num_sem
         $error("sem_bank: NUM_SEM must be a power of two of at least 2");
      end
      if (NUM_REQ < 1 || DATA_W < 1 || OWNER_W < 1) begin : g_bad_width
         $error("sem_bank: NUM_REQ, DATA_W and OWNER_W must be positive");
      end
      if (BASE_ADDR[2:0] != 3'b000) begin : g_bad_base
         $error("sem_bank: BASE_ADDR must be 8-byte aligned");
      end
      if (ADDR_W < IDX_W + 3) begin : g_bad_addr_w
         $error("sem_bank: ADDR_W too narrow for the window");
      end
   endgenerate

   sem_acc_e           acc_kind [NUM_REQ];
   logic [IDX_W-1:0]   acc_idx  [NUM_REQ];
   logic [NUM_REQ-1:0] lock_req [NUM_SEM];
   logic [NUM_REQ-1:0] gnt_m    [NUM_SEM];
   logic [NUM_SEM-1:0] rel_req;
   logic [NUM_REQ-1:0] win;
   logic [NUM_REQ-1:0] rsp_valid_q;
   logic [NUM_REQ-1:0] rsp_win_q;

   genvar gr, gs;
   generate
      for (gr = 0; gr < NUM_REQ; gr++) begin : g_dec
         sem_addr_dec #(
            .ADDR_W    (ADDR_W),
            .NUM_SEM   (NUM_SEM),
            .BASE_ADDR (BASE_ADDR)
         ) u_dec (
            .valid (req_valid[gr]),
            .write (req_write[gr]),
            .addr  (req_addr[gr*ADDR_W +: ADDR_W]),
            .kind  (acc_kind[gr]),
            .idx   (acc_idx[gr])
         );
      end
   endgenerate

   always_comb begin
      for (int s = 0; s < NUM_SEM; s++) begin
         lock_req[s] = '0;
         rel_req[s]  = 1'b0;
         for (int r = 0; r < NUM_REQ; r++) begin
            if (acc_kind[r] == ACC_LOCK && acc_idx[r] == IDX_W'(s))
               lock_req[s][r] = 1'b1;
            if (acc_kind[r] == ACC_UNLOCK && acc_idx[r] == IDX_W'(s))
               rel_req[s] = 1'b1;
         end
      end
   end

   generate
      for (gs = 0; gs < NUM_SEM; gs++) begin : g_sem
         sem_cell #(
            .NUM_REQ  (NUM_REQ),
            .OWNER_W  (OWNER_W),
            .OWNER_EN (OWNER_EN)
         ) u_cell (
            .clk         (clk),
            .rst         (rst),
            .lock_req    (lock_req[gs]),
            .release_req (rel_req[gs]),
            .tags        (req_tag),
            .held        (sem_held[gs]),
            .gnt         (gnt_m[gs]),
            .owner       (sem_owner[gs*OWNER_W +: OWNER_W])
         );
      end
   endgenerate

   always_comb begin
      win = '0;
      for (int s = 0; s < NUM_SEM; s++)
         win = win | gnt_m[s];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid_q <= '0;
         rsp_win_q   <= '0;
      end else begin
         rsp_valid_q <= req_valid;
         rsp_win_q   <= win;
      end
   end

   assign rsp_valid = rsp_valid_q;

   always_comb begin
      for (int r = 0; r < NUM_REQ; r++)
         rsp_rdata[r*DATA_W +: DATA_W] = DATA_W'(rsp_win_q[r]);
   end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
   parameter int NUM_SEM = 8,
   parameter int NUM_REQ = 2,
   parameter int DATA_W  = 32,
   parameter int OWNER_W = 4
) (
   input logic                       clk,
   input logic                       rst,
   input logic [NUM_REQ-1:0]         req_valid,
   input logic [NUM_REQ-1:0]         req_write,
   input logic [NUM_REQ-1:0]         rsp_valid,
   input logic [NUM_REQ*DATA_W-1:0]  rsp_rdata,
   input logic [NUM_SEM-1:0]         sem_held,
   input logic [NUM_SEM*OWNER_W-1:0] sem_owner
);
   logic [NUM_REQ-1:0] rsp_win;
   always_comb begin
      for (int r = 0; r < NUM_REQ; r++)
         rsp_win[r] = rsp_valid[r] && rsp_rdata[r*DATA_W];
   end

   a_r1_reset_frees: assert property (@(posedge clk) rst |=> (sem_held == '0));

   a_r5_one_win_per_new_hold: assert property (@(posedge clk) disable iff (rst)
      $countones(rsp_win) == $countones(sem_held & ~$past(sem_held)));

   a_r9_idle_keeps_state: assert property (@(posedge clk) disable iff (rst)
      !$past(|req_valid) |-> $stable(sem_held));

   genvar gr, gs;
   generate
      for (gr = 0; gr < NUM_REQ; gr++) begin : g_req
         a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[gr] |-> $past(req_valid[gr]));
         a_r8_write_reads_zero: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid[gr] && $past(req_write[gr])) |-> (rsp_rdata[gr*DATA_W +: DATA_W] == '0));
      end
      for (gs = 0; gs < NUM_SEM; gs++) begin : g_sem
         a_r10_owner_zero_when_free: assert property (@(posedge clk) disable iff (rst)
            !sem_held[gs] |-> (sem_owner[gs*OWNER_W +: OWNER_W] == '0));
      end
   endgenerate
endmodule

bind sem_bank sem_bank_chk #(
   .NUM_SEM (NUM_SEM),
   .NUM_REQ (NUM_REQ),
   .DATA_W  (DATA_W),
   .OWNER_W (OWNER_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_write (req_write),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .sem_held  (sem_held),
   .sem_owner (sem_owner)
);

// File: tb/tb_sem_bank.sv
`timescale 1ns/1ps
module tb_sem_bank;
   localparam int NS = 8, NR = 2, AW = 20, DW = 32, OW = 4;
   localparam logic [AW-1:0] BASE = 20'h1C000;
   localparam logic [OW-1:0] TAG0 = 4'h3, TAG1 = 4'h9;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [NR-1:0]      req_valid = '0;
   logic [NR-1:0]      req_write = '0;
   logic [NR*AW-1:0]   req_addr  = '0;
   logic [NR*OW-1:0]   req_tag   = {TAG1, TAG0};
   logic [NR-1:0]      rsp_valid;
   logic [NR*DW-1:0]   rsp_rdata;
   logic [NS-1:0]      sem_held;
   logic [NS*OW-1:0]   sem_owner;

   int nchk = 0, nerr = 0;
   logic [DW-1:0] rd0, rd1;
   logic [NR-1:0] rv;

   sem_bank dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_tag(req_tag), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .sem_held(sem_held), .sem_owner(sem_owner)
   );

   always #2.5 clk = ~clk;

   function automatic logic [AW-1:0] lk(int n); return BASE + AW'(8*n); endfunction
   function automatic logic [AW-1:0] ul(int n); return BASE + AW'(8*n + 4); endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic op(input logic v0, input logic w0, input logic [AW-1:0] a0,
                     input logic v1, input logic w1, input logic [AW-1:0] a1);
      @(negedge clk);
      req_valid = {v1, v0};
      req_write = {w1, w0};
      req_addr  = {a1, a0};
      @(posedge clk);
      #1;
      rd0 = rsp_rdata[0 +: DW];
      rd1 = rsp_rdata[DW +: DW];
      rv  = rsp_valid;
      req_valid = '0;
   endtask

   function automatic logic [DW-1:0] own(int n); return DW'(sem_owner[n*OW +: OW]); endfunction

   task automatic t_reset;
      chk("R1 held after reset", DW'(sem_held), 0);
      chk("R1 owners after reset", DW'(sem_owner), 0);
      chk("R1 rsp_valid after reset", DW'(rsp_valid), 0);
   endtask

   task automatic t_basic;
      op(1, 0, lk(2), 0, 0, '0);
      chk("R3 grant data", rd0, 1);
      chk("R2 rsp_valid one cycle later", DW'(rv), 2'b01);
      chk("R3 held bit", DW'(sem_held), 8'h04);
      chk("R10 owner tag", own(2), DW'(TAG0));
      @(posedge clk); #1;
      chk("R2 rsp_valid drops", DW'(rsp_valid), 0);
      op(0, 0, '0, 1, 0, lk(2));
      chk("R4 busy data", rd1, 0);
      chk("R4 state unchanged", DW'(sem_held), 8'h04);
      chk("R4 owner unchanged", own(2), DW'(TAG0));
      op(0, 0, '0, 1, 0, ul(2));
      chk("R7 release data", rd1, 0);
      chk("R7 released", DW'(sem_held), 0);
      chk("R10 owner cleared", own(2), 0);
      op(0, 0, '0, 1, 0, ul(2));
      chk("R7 release of free", DW'(sem_held), 0);
   endtask

   task automatic t_all;
      for (int n = 0; n < NS; n++) begin
         op(0, 0, '0, 1, 0, lk(n));
         chk($sformatf("R2 acquire sem %0d", n), rd1, 1);
         chk($sformatf("R2 held map sem %0d", n), DW'(sem_held), DW'((1 << (n + 1)) - 1));
      end
      for (int n = 0; n < NS; n++) op(1, 0, ul(n), 0, 0, '0);
      chk("R7 any requester releases all", DW'(sem_held), 0);
   endtask

   task automatic t_race;
      op(1, 0, lk(5), 1, 0, lk(5));
      chk("R5 low index wins", rd0, 1);
      chk("R5 high index loses", rd1, 0);
      chk("R5 single hold", DW'(sem_held), 8'h20);
      chk("R5 owner of winner", own(5), DW'(TAG0));
      op(0, 0, '0, 1, 0, ul(5));
      op(1, 0, lk(0), 1, 0, lk(7));
      chk("R6 req0 granted", rd0, 1);
      chk("R6 req1 granted", rd1, 1);
      chk("R6 both held", DW'(sem_held), 8'h81);
      chk("R6 owner sem7", own(7), DW'(TAG1));
      op(1, 0, ul(0), 1, 0, ul(7));
      chk("R7 dual release", DW'(sem_held), 0);
   endtask

   task automatic t_writes;
      op(1, 1, lk(3), 0, 0, '0);
      chk("R8 write to acquire addr", DW'(sem_held), 0);
      chk("R8 write data zero", rd0, 0);
      chk("R2 write gets rsp_valid", DW'(rv), 2'b01);
      op(1, 0, lk(3), 0, 0, '0);
      op(0, 0, '0, 1, 1, ul(3));
      chk("R8 write to release addr", DW'(sem_held), 8'h08);
      op(1, 0, ul(3), 0, 0, '0);
   endtask

   task automatic t_outside;
      op(1, 0, BASE + AW'(8*NS), 1, 0, BASE - AW'(8));
      chk("R9 above window data", rd0, 0);
      chk("R9 below window data", rd1, 0);
      chk("R9 no state", DW'(sem_held), 0);
      op(1, 0, lk(1) + AW'(1), 1, 0, lk(4) + AW'(2));
      chk("R9 misaligned data", rd0 | rd1, 0);
      chk("R9 misaligned no state", DW'(sem_held), 0);
      op(1, 0, lk(6) ^ AW'(20'h40000 & ((1 << AW) - 1)), 0, 0, '0);
      chk("R9 alias no state", DW'(sem_held), 0);
   endtask

   task automatic t_same_cycle;
      op(1, 0, lk(6), 0, 0, '0);
      op(1, 0, lk(6), 1, 0, ul(6));
      chk("R11 acquire on held loses", rd0, 0);
      chk("R11 held then freed", DW'(sem_held), 0);
      op(1, 0, ul(6), 1, 0, lk(6));
      chk("R11 acquire on free wins", rd1, 1);
      chk("R11 free then held", DW'(sem_held), 8'h40);
      chk("R11 owner", own(6), DW'(TAG1));
      op(1, 0, ul(6), 0, 0, '0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst = 1'b0;
      t_basic();
      t_all();
      t_race();
      t_writes();
      t_outside();
      t_same_cycle();
      op(1, 0, lk(1), 0, 0, '0);
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      chk("R1 reset frees held sem", DW'(sem_held), 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #500000;
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule